// File: doc/BRIEF.md
# Multi-Length Serial Audio Input Deserializer

This block receives two-channel serial audio made of a bit clock, a data line and a left/right word clock. All three lines are brought into the system clock domain through synchroniser chains, and the block detects their edges there. On every falling bit-clock edge the data bit enters a 32-bit shift register, MSB first.

Words are rear-packed: the LSB of a word is the last bit before the word clock toggles. On a word-clock transition the block takes the word that just ended. It assigns that word to a channel from the word-clock level during the word and a polarity select. It then normalises the word to a 24-bit sample for the length chosen by a 2-bit code. When both channels of a frame have been taken, the block publishes the left and right samples together with a single-cycle pair-valid strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: The data line is sampled on each falling edge of the synchronised bit clock and shifted into a 32-bit register with the first bit sent ending up most significant (MSB first).
- R2: On a word-clock transition only the last N captured bits form the word, where N is the selected length. Bits sent earlier in the same half period do not affect the output.
- R3: With `chan_pol_i` high, a word sent while the word clock was high goes to the left channel and a word sent while it was low goes to the right channel. With `chan_pol_i` low the assignment is reversed.
- R4: `len_sel_i` encodes the word length as 2'b00 = 32 bits, 2'b01 = 16 bits, 2'b10 = 24 bits, 2'b11 = 20 bits. It is sampled at the word-clock transition that ends the word.
- R5: A 32-bit word keeps its upper 24 bits. The lower 8 bits are dropped with no rounding.
- R6: A 24-bit word is passed through unchanged as the 24-bit sample.
- R7: A 20-bit word is shifted up with 4 zero LSBs appended. A 16-bit word is shifted up with 8 zero LSBs appended.
- R8: `pair_valid_o` is high for exactly one cycle once one left and one right word have been taken since the previous strobe. `left_o` and `right_o` change only in the cycle where `pair_valid_o` is high.
- R9: The first word-clock transition after reset only marks the start of a word and latches nothing, so one pair strobe follows per complete frame.
- R10: While reset is asserted and after its release, `left_o` and `right_o` are zero and `pair_valid_o` is low until the first pair is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| bdata_i | input | 1 | Serial data, MSB first, rear-packed |
| wclk_i | input | 1 | Left/right word clock |
| chan_pol_i | input | 1 | Word-clock polarity select |
| len_sel_i | input | 2 | Word length code |
| left_o | output | 24 | Left sample, 24-bit two's complement |
| right_o | output | 24 | Right sample, 24-bit two's complement |
| pair_valid_o | output | 1 | One-cycle strobe for a new left/right pair |

## Verification
The bench builds the block with its default two-stage synchronisers and a bit clock of eight system cycles per period. With these settings every word-clock transition lands several cycles after the last falling bit-clock edge, and the whole 64-slot frame stays short enough to run all four length codes under both polarities. Each half period carries a full 32-bit random vector. This places random upper bits ahead of every shorter word, which exercises the ignored-bit rule. Directed extreme patterns expose bit order, truncation and padding.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int WORD_W = 32;
    localparam int SMP_W  = 24;
    localparam int PAD20  = SMP_W - 20;
    localparam int PAD16  = SMP_W - 16;

    typedef enum logic [1:0] {
        LEN_32 = 2'b00,
        LEN_16 = 2'b01,
        LEN_24 = 2'b10,
        LEN_20 = 2'b11
    } len_sel_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sar_align.sv
module sar_align
    import sar_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [1:0]        len_sel_i,
    output logic [SMP_W-1:0]  sample_o
);
    always_comb begin
        unique case (len_sel_e'(len_sel_i))
            LEN_32:  sample_o = word_i[WORD_W-1 -: SMP_W];
            LEN_24:  sample_o = word_i[SMP_W-1:0];
            LEN_20:  sample_o = SMP_W'(word_i[19:0]) << PAD20;
            default: sample_o = SMP_W'(word_i[15:0]) << PAD16;
        endcase
    end
endmodule

// File: rtl/sar_pair.sv
module sar_pair
    import sar_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_l_i,
    input  logic             take_r_i,
    input  logic [SMP_W-1:0] sample_i,
    output logic [SMP_W-1:0] left_o,
    output logic [SMP_W-1:0] right_o,
    output logic             valid_o
);
    typedef struct packed {
        logic [SMP_W-1:0] hold_l;
        logic [SMP_W-1:0] hold_r;
        logic             have_l;
        logic             have_r;
        logic [SMP_W-1:0] out_l;
        logic [SMP_W-1:0] out_r;
        logic             valid;
    } pair_state_t;

    pair_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (take_l_i) begin
            st_d.hold_l = sample_i;
            st_d.have_l = 1'b1;
        end
        if (take_r_i) begin
            st_d.hold_r = sample_i;
            st_d.have_r = 1'b1;
        end
        if (st_d.have_l && st_d.have_r) begin
            st_d.out_l  = st_d.hold_l;
            st_d.out_r  = st_d.hold_r;
            st_d.valid  = 1'b1;
            st_d.have_l = 1'b0;
            st_d.have_r = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_o  = st_q.out_l;
    assign right_o = st_q.out_r;
    assign valid_o = st_q.valid;

    // R3
    one_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_l_i, take_r_i}));

    // R8
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |=> !st_q.valid);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.out_l != $past(st_q.out_l) || st_q.out_r != $past(st_q.out_r)) |-> st_q.valid);
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sar_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    input  logic             bdata_i,
    input  logic             wclk_i,
    input  logic             chan_pol_i,
    input  logic [1:0]       len_sel_i,
    output logic [SMP_W-1:0] left_o,
    output logic [SMP_W-1:0] right_o,
    output logic             pair_valid_o
);
    typedef struct packed {
        logic              bclk_prev;
        logic              wclk_prev;
        logic [WORD_W-1:0] shift;
        logic              armed;
    } rx_state_t;

    rx_state_t st_d, st_q;

    logic [2:0]       sync_q;
    logic             bclk_s, bdata_s, wclk_s;
    logic             bclk_fall, wclk_edge;
    logic             take_word, take_l, take_r;
    logic [SMP_W-1:0] aligned;

    sar_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bclk_i, bdata_i, wclk_i}),
        .q_o   (sync_q)
    );

    assign {bclk_s, bdata_s, wclk_s} = sync_q;

    always_comb begin
        st_d           = st_q;
        bclk_fall      = st_q.bclk_prev & ~bclk_s;
        wclk_edge      = st_q.wclk_prev ^ wclk_s;
        st_d.bclk_prev = bclk_s;
        st_d.wclk_prev = wclk_s;
        if (bclk_fall) st_d.shift = {st_q.shift[WORD_W-2:0], bdata_s};
        if (wclk_edge) st_d.armed = 1'b1;
        take_word = wclk_edge & st_q.armed;
        take_l    = take_word & (st_q.wclk_prev == chan_pol_i);
        take_r    = take_word & (st_q.wclk_prev != chan_pol_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sar_align i_align (
        .word_i    (st_q.shift),
        .len_sel_i (len_sel_i),
        .sample_o  (aligned)
    );

    sar_pair i_pair (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_l_i (take_l),
        .take_r_i (take_r),
        .sample_i (aligned),
        .left_o   (left_o),
        .right_o  (right_o),
        .valid_o  (pair_valid_o)
    );

    // R1
    shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_fall |=> st_q.shift[0] == $past(bdata_s));

    // R7
    pad16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_word && len_sel_i == LEN_16) |-> aligned[PAD16-1:0] == '0);

    // R7
    pad20_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_word && len_sel_i == LEN_20) |-> aligned[PAD20-1:0] == '0);

    // R9
    first_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |=> !pair_valid_o);
endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, bdata = 1'b0, wclk = 1'b0, pol = 1'b1;
    logic [1:0]  len = 2'b01;
    logic [23:0] left_o, right_o;
    logic        pair_valid_o;

    int checks = 0, errors = 0, pulses = 0;
    logic [23:0] got_l [0:255];
    logic [23:0] got_r [0:255];

    always #10 clk = ~clk;

    serial_audio_rx i_serial_audio_rx (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .bdata_i(bdata), .wclk_i(wclk),
        .chan_pol_i(pol), .len_sel_i(len), .left_o(left_o), .right_o(right_o),
        .pair_valid_o(pair_valid_o)
    );

    always @(negedge clk) begin
        if (pair_valid_o && pulses < 256) begin
            got_l[pulses] = left_o;
            got_r[pulses] = right_o;
        end
        if (pair_valid_o) pulses++;
    end

    // R4 codes: 00=32, 01=16, 10=24, 11=20
    function automatic logic [23:0] expect_smp(logic [31:0] v, logic [1:0] code);
        case (code)
            2'b00:   return v[31:8];              // R5
            2'b10:   return v[23:0];              // R6
            2'b11:   return {v[19:0], 4'h0};      // R7
            default: return {v[15:0], 8'h00};     // R7
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] code);
        case (code)
            2'b00:   return "R1 R2 R3 R4 R5";
            2'b10:   return "R1 R2 R3 R4 R6";
            default: return "R1 R2 R3 R4 R7";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_half(logic level, logic [31:0] v);
        for (int j = 0; j < 32; j++) begin
            @(negedge clk);
            bclk  = 1'b1;
            bdata = v[31-j];
            if (j == 0) wclk = level;
            repeat (4) @(negedge clk);
            bclk = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic run(logic p, logic [1:0] code, int frames, logic [31:0] d1, logic [31:0] d0);
        logic [31:0] v1, v0;
        logic [23:0] el [0:15];
        logic [23:0] er [0:15];
        int base;
        rst_n = 1'b0; wclk = 1'b0; bclk = 1'b0; bdata = 1'b0;
        pol = p; len = code;
        repeat (4) @(negedge clk);
        // R10
        check("R10 reset left", {8'h0, left_o}, 32'h0);
        check("R10 reset strobe", {31'h0, pair_valid_o}, 32'h0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R10 post-reset right", {8'h0, right_o}, 32'h0);
        base = pulses;
        send_half(1'b0, $urandom());
        for (int f = 0; f < frames; f++) begin
            v1 = (f == 0) ? d1 : $urandom();
            v0 = (f == 0) ? d0 : $urandom();
            send_half(1'b1, v1);
            send_half(1'b0, v0);
            el[f] = p ? expect_smp(v1, code) : expect_smp(v0, code);
            er[f] = p ? expect_smp(v0, code) : expect_smp(v1, code);
        end
        send_half(1'b1, $urandom());
        repeat (10) @(negedge clk);
        // R8 R9: one strobe per complete frame, none for the arming edge
        check("R8 R9 pair count", pulses - base, frames);
        for (int f = 0; f < frames && base + f < 256; f++) begin
            check({tag_of(code), " R8 left"},  {8'h0, got_l[base+f]}, {8'h0, el[f]});
            check({tag_of(code), " R8 right"}, {8'h0, got_r[base+f]}, {8'h0, er[f]});
        end
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        join_none
        void'($urandom(32'd2024));
        // directed corners per length and polarity
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 2; p++) begin
                run(p[0], c[1:0], 3, 32'h8000_00FF, 32'h7FFF_FF01);
            end
        end
        run(1'b1, 2'b01, 2, 32'hFFFF_8000, 32'h0000_7FFF);
        run(1'b0, 2'b11, 2, 32'hABC8_0001, 32'h5437_FFFE);
        // random runs
        for (int k = 0; k < 4; k++) begin
            run(1'($urandom()), 2'($urandom()), 4, $urandom(), $urandom());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule